// File: doc/BRIEF.md
# Routed Level-Sensitive Interrupt Controller

This block collects nine level-sensitive interrupt inputs and steers them onto three interrupt request outputs for a host interrupt controller. Each input passes through a two-flop synchronizer. It is then compared against its effective active level, which comes either from a software polarity register or from a level fixed at build time.

Every output line owns one 32-bit register. The low half of that register holds the per-source enables. The upper half reports pending status, and software clears a pending bit by writing a one to it. A source is routed to a line by enabling it in that line's register. Once a pending bit is captured, it holds until software acknowledges it. An output line stays asserted while any of its pending bits is set.

The bus side is a plain word-addressed register port. Writes take effect on the clock edge and reads are combinational.

Top module: `lvl_irq_router`

## Requirements
- R1: The register at byte offset 0x0 holds per-source polarity in bits [8:0]. A 1 in bit i makes source i active-high and a 0 makes it active-low. All nine bits read back as written.
- R2: Sources 1 and 8 are always active-high and source 2 is always active-low, whatever the polarity register holds. The other sources follow the polarity register.
- R3: The register of output line n sits at byte offset 0x4 + 4*n. Its bits [8:0] are the enables of sources 0..8 for that line and read back as written.
- R4: Pending bit 16+i of line n becomes 1 when source i is at its active level and enable bit i of line n is 1. A source whose enable bit is 0 never sets that line's pending bit.
- R5: Writing 1 to bit 16+i of a line register clears that pending bit unless source i is still active and enabled, in which case the bit stays 1. Writing 0 to a pending bit leaves it unchanged.
- R6: Output irq_out[n] is 1 exactly when line n has at least one pending bit set.
- R7: A pending bit stays 1 after its source returns to the inactive level, until it is acknowledged.
- R8: After reset, the polarity register, all enables and all pending bits are 0, and every irq_out bit is 0.
- R9: A change on src_in shows up in the pending bits at the third rising clock edge after it is applied, because of the two synchronizer stages.
- R10: Bits [15:9] and [31:25] of the line registers and bits [31:9] of the polarity register read as 0. Offsets above 0xC read as 0, and writes to them change nothing.
- R11: Writing 0x01FF0000 to a line register leaves that line with every enable and pending bit at 0 and its output low, even while sources are active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 9 | Raw interrupt source levels |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 6 | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_out | output | 3 | Interrupt request outputs, active high |

## Verification
A wrong enable or polarity bit shows at the ports as a pending bit and an irq_out level that appear for the wrong source or line. These become visible three edges after the source changes. A corrupted pending bit is visible at once on the line's read value and on irq_out. Because pending bits are sticky, such an error persists until the next acknowledge instead of fading. The sweep drives every source onto every line under both polarity settings, so a mis-steered or mis-inverted source shows within four cycles of its stimulus.

// File: rtl/lvl_irq_router.sv
module lvl_irq_router #(
  parameter int NSRC = 9,
  parameter int NLINE = 3,
  parameter int AW = 6,
  parameter logic [NSRC-1:0] FIX_MASK = 9'h106,
  parameter logic [NSRC-1:0] FIX_HIGH = 9'h102
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [NLINE-1:0] irq_out
);
  localparam int PB = 16;
  localparam int WI = AW - 2;

  logic [NSRC-1:0] sync1, sync2, pol_q, act_high, active;
  logic [NSRC-1:0] en_q [NLINE];
  logic [NSRC-1:0] pend_q [NLINE];
  logic [NSRC*NLINE-1:0] en_flat, pend_flat;
  logic [WI-1:0] widx;

  assign widx     = bus_addr[AW-1:2];
  assign act_high = (FIX_MASK & FIX_HIGH) | (~FIX_MASK & pol_q);
  assign active   = ~(sync2 ^ act_high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      pol_q <= '0;
    end else begin
      sync1 <= src_in;
      sync2 <= sync1;
      if (bus_we && widx == '0) pol_q <= bus_wdata[NSRC-1:0];
    end
  end

  genvar n;
  generate
    for (n = 0; n < NLINE; n++) begin : g_line
      logic            hit;
      logic [NSRC-1:0] en_nx, ack;
      assign hit   = bus_we && (widx == WI'(n + 1));
      assign en_nx = hit ? bus_wdata[NSRC-1:0] : en_q[n];
      assign ack   = hit ? bus_wdata[PB +: NSRC] : '0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q[n]   <= '0;
          pend_q[n] <= '0;
        end else begin
          en_q[n]   <= en_nx;
          pend_q[n] <= (pend_q[n] & ~ack) | (active & en_nx);
        end
      end
      assign irq_out[n] = |pend_q[n];
      assign en_flat[n*NSRC +: NSRC]   = en_q[n];
      assign pend_flat[n*NSRC +: NSRC] = pend_q[n];
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (widx == '0) bus_rdata[NSRC-1:0] = pol_q;
    for (int k = 0; k < NLINE; k++) begin
      if (widx == WI'(k + 1)) begin
        bus_rdata[NSRC-1:0]    = en_q[k];
        bus_rdata[PB +: NSRC]  = pend_q[k];
      end
    end
  end
endmodule

module lvl_irq_router_chk #(
  parameter int NSRC = 9,
  parameter int NLINE = 3,
  parameter int AW = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_we,
  input logic [AW-1:0]         bus_addr,
  input logic [NSRC-1:0]       pol_q,
  input logic [NSRC*NLINE-1:0] en_flat,
  input logic [NSRC*NLINE-1:0] pend_flat,
  input logic [NLINE-1:0]      irq_out
);
  a_r8_reset_clean: assert property (@(posedge clk)
    $rose(rst_n) |-> (pend_flat == '0 && en_flat == '0 && pol_q == '0 && irq_out == '0));

  a_r4_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_flat & ~$past(pend_flat) & ~en_flat) == '0);

  a_r7_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_flat) & ~pend_flat) != '0) |-> $past(bus_we));

  a_r1_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_we) |-> $stable(pol_q));

  genvar n;
  generate
    for (n = 0; n < NLINE; n++) begin : g_chk
      a_r6_irq_fall_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out[n]) |-> $past(bus_we && bus_addr[AW-1:2] == (AW-2)'(n + 1)));
    end
  endgenerate
endmodule

bind lvl_irq_router lvl_irq_router_chk #(.NSRC(NSRC), .NLINE(NLINE), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .pol_q(pol_q),
  .en_flat(en_flat), .pend_flat(pend_flat), .irq_out(irq_out)
);

// File: tb/lvl_irq_router_tb_top.sv
module lvl_irq_router_tb_top;
  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [8:0] src_in = '0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [2:0] irq_out;
  int checks = 0, fails = 0;

  lvl_irq_router dut_i (.clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  always #4 clk = ~clk;

  function automatic logic hi_act(int i, logic [8:0] pol);
    if (i == 1 || i == 8) return 1'b1;
    if (i == 2) return 1'b0;
    return pol[i];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(string req, logic [5:0] a, logic [31:0] exp);
    bus_addr = a; #1; chk(req, bus_rdata, exp);
  endtask

  task automatic step(int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(logic [8:0] pol);
    for (int i = 0; i < 9; i++) src_in[i] = ~hi_act(i, pol);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [8:0] pol;
    idle(9'h0);
    step(3); rst_n = 1; @(negedge clk);
    rd("R8", 6'h0, 0); rd("R8", 6'h4, 0); rd("R8", 6'h8, 0); rd("R8", 6'hC, 0);
    chk("R8", {29'd0, irq_out}, 0);
    wr(6'h0, 32'hFFFF_FFFF); rd("R1", 6'h0, 32'h1FF); rd("R10", 6'h0, 32'h1FF);
    wr(6'h0, 0); rd("R1", 6'h0, 0);

    for (int p = 0; p < 2; p++) begin
      pol = p ? 9'h1FF : 9'h0;
      for (int l = 0; l < 3; l++) wr(6'(4 + 4*l), 32'h01FF_0000);
      wr(6'h0, {23'd0, pol}); idle(pol); step(3);
      for (int l = 0; l < 3; l++) wr(6'(4 + 4*l), 32'h01FF_0000);
      for (int n = 0; n < 3; n++) begin
        for (int i = 0; i < 9; i++) begin
          wr(6'(4 + 4*n), 32'(1) << i);
          rd("R3", 6'(4 + 4*n), 32'(1) << i);
          src_in[i] = hi_act(i, pol);
          step(3);
          rd(i inside {1, 2, 8} ? "R2" : "R4", 6'(4 + 4*n), (32'(1) << (16 + i)) | (32'(1) << i));
          chk("R6", {29'd0, irq_out}, 32'(1) << n);
          for (int m = 0; m < 3; m++) if (m != n) rd("R4", 6'(4 + 4*m), 0);
          src_in[i] = ~hi_act(i, pol);
          step(3);
          rd("R7", 6'(4 + 4*n), (32'(1) << (16 + i)) | (32'(1) << i));
          wr(6'(4 + 4*n), (32'(1) << (16 + i)) | (32'(1) << i));
          rd("R5", 6'(4 + 4*n), 32'(1) << i);
          chk("R6", {29'd0, irq_out}, 0);
          wr(6'(4 + 4*n), 0);
        end
      end
    end

    // pol = all ones here; source 3 active-high
    idle(9'h1FF);
    wr(6'h4, 32'h1F7);
    src_in[3] = 1; step(4);
    rd("R4", 6'h4, 32'h1F7);
    chk("R4", {29'd0, irq_out}, 0);
    src_in[3] = 0; wr(6'h4, 0); step(3);

    // R9 latency: source 0 on line 1
    wr(6'h8, 32'h1);
    src_in[0] = 1;
    step(2); rd("R9", 6'h8, 32'h1);
    step(1); rd("R9", 6'h8, 32'h0001_0001);
    // ack while still active keeps it set
    wr(6'h8, 32'h0001_0001); rd("R5", 6'h8, 32'h0001_0001);
    // writing 0 to pending bits has no effect
    src_in[0] = 0; step(3);
    wr(6'h8, 32'h1); rd("R5", 6'h8, 32'h0001_0001);
    // clean-state write while source active
    src_in[0] = 1; step(3);
    wr(6'h8, 32'h01FF_0000); rd("R11", 6'h8, 0);
    chk("R11", {29'd0, irq_out}, 0);
    step(2); rd("R11", 6'h8, 0);
    src_in[0] = 0; step(3);

    // R10 unused bits and offsets
    wr(6'hC, 32'hFE00_FE00); rd("R10", 6'hC, 0);
    wr(6'h10, 32'hFFFF_FFFF); wr(6'h3C, 32'hFFFF_FFFF);
    rd("R10", 6'h10, 0); rd("R10", 6'h3C, 0);
    rd("R10", 6'h0, 32'h1FF); rd("R10", 6'h4, 0); rd("R10", 6'h8, 0); rd("R10", 6'hC, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule